// File: doc/BRIEF.md
# Pipelined Configuration Port Bridge

This block connects a processor's register interface to the dynamic reconfiguration port of a fixed on-chip macro, such as an analog sensor or a clock generator. To start an access, software sets an address and write data, then pulses a read strobe or a write strobe. A register stage sits between the strobe and the port. The enable pulse, address, write data and write-enable therefore all leave the block together, one clock after the strobe. This lets the long routing run to the macro start from a flop rather than from the deep logic that decodes the register bus. Software then polls a ready bit and reads back the latched return data.

The block also decides who owns the port, using a mode input. While the mode input is 0, a built-in scan sequencer keeps reading a fixed set of sensor channels. It stores each result in its own slot of a readable status vector. Setting the mode input to 1 parks the sequencer and gives the port to software. Any access the sequencer already has in flight is finished first. Clearing the mode input hands the port back to the sequencer.

Two state machines drive the block. The scan machine has three states:
- SCAN_ISSUE presents a read request.
- SCAN_WAIT waits for the port's ready pulse.
- SCAN_PARKED has given the port to software.

Its transitions are:
- issue-accepted: SCAN_ISSUE to SCAN_WAIT.
- mode-set-idle: SCAN_ISSUE to SCAN_PARKED.
- reply-continue: SCAN_WAIT to SCAN_ISSUE, moving to the next channel.
- reply-park: SCAN_WAIT to SCAN_PARKED, when the mode input is 1.
- mode-cleared: SCAN_PARKED to SCAN_ISSUE.

The software machine has two states, SW_IDLE and SW_BUSY. Its transitions are strobe-accepted (SW_IDLE to SW_BUSY) and reply-received (SW_BUSY to SW_IDLE).

Top module: `cfgport_bridge`

## Requirements
- R1: When a strobe is accepted at a clock edge, `port_en_o` is high for exactly the following cycle and low in the cycle after that.
- R2: `port_addr_o`, `port_wdata_o` and `port_we_o` are loaded in the same register stage as the enable. They show the accepted request's values in the enable cycle and hold them until the next accepted request.
- R3: A read strobe issues a request with `port_we_o`=0. A write strobe issues a request with `port_we_o`=1. If both strobes are high in the same cycle, the write is issued.
- R4: `sw_ready_o` is 1 after reset. It reads 0 from the edge that accepts a software strobe. It reads 1 again from the edge that samples `port_rdy_i` for that request, and `sw_rdata_o` takes `port_rdata_i` at that same edge.
- R5: While the mode input is 0, the scan machine reads channels 0 to N_CH-1 in turn, at port address SCAN_BASE+i, with `port_we_o`=0. Each result is stored in bits [i*DW +: DW] of `scan_vals_o`.
- R6: When the mode input is set, the scan machine issues no new request. It completes any request already pending, then parks. Software strobes are accepted only while the machine is parked.
- R7: When the mode input is cleared, the scan machine resumes reading channels once no software response is pending. Changed channel contents then appear in `scan_vals_o`.
- R8: A strobe that cannot be accepted makes no port access. This covers a strobe while a response is pending, while the mode input is 0, or before the scan machine has parked. Such a strobe sets `sw_overrun_o`, which stays 1 until reset.
- R9: `port_en_o` is never high on two consecutive cycles. No enable is issued while a response is still pending.
- R10: After reset, `port_en_o`=0, `sw_ready_o`=1, `sw_overrun_o`=0 and `scan_vals_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_mode_i | input | 1 | 1 gives the port to software, 0 to the scan machine |
| sw_rd_stb_i | input | 1 | Software read strobe, one cycle |
| sw_wr_stb_i | input | 1 | Software write strobe, one cycle |
| sw_addr_i | input | AW | Software request address |
| sw_wdata_i | input | DW | Software write data |
| sw_ready_o | output | 1 | No software request outstanding |
| sw_rdata_o | output | DW | Data returned with the last software reply |
| sw_overrun_o | output | 1 | Sticky flag: a strobe was ignored |
| scan_vals_o | output | N_CH*DW | Latest scanned channel values |
| port_en_o | output | 1 | Port enable pulse |
| port_we_o | output | 1 | Port write-enable |
| port_addr_o | output | AW | Port address |
| port_wdata_o | output | DW | Port write data |
| port_rdata_i | input | DW | Port return data |
| port_rdy_i | input | 1 | Port ready pulse |

## Verification
A table of writes and reads runs against the bench's macro model, with the reply latency varied from entry to entry. This separates data that is really returned from the port from stale latched data, and it checks that the enable arrives exactly one cycle after the strobe. Further strobes are aimed at the cases where they must be refused:
- while a reply is pending;
- while the scan machine still owns the port;
- while a handover is in progress.

Each of these must leave both the enable count and the macro contents unchanged. Scan contents are compared before and after software changes a channel. This shows that the scan machine keeps its channel order and really does resume when the mode input is cleared.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        SCAN_ISSUE  = 2'd0,
        SCAN_WAIT   = 2'd1,
        SCAN_PARKED = 2'd2
    } scan_state_t;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_BUSY = 1'b1
    } sw_state_t;

    typedef enum logic {
        SRC_SCAN = 1'b0,
        SRC_SW   = 1'b1
    } req_src_t;

endpackage

// File: rtl/cfgport_issue.sv
module cfgport_issue
    import cfgport_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  req_src_t      req_src,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          port_rdy_i,
    output logic          accept,
    output logic          pending,
    output logic          done_scan,
    output logic          done_sw,
    output logic          port_en_o,
    output logic          port_we_o,
    output logic [AW-1:0] port_addr_o,
    output logic [DW-1:0] port_wdata_o
);

    req_src_t src_q;

    assign accept    = req_valid && !pending;
    assign done_scan = pending && port_rdy_i && (src_q == SRC_SCAN);
    assign done_sw   = pending && port_rdy_i && (src_q == SRC_SW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_o    <= 1'b0;
            port_we_o    <= 1'b0;
            port_addr_o  <= '0;
            port_wdata_o <= '0;
            pending      <= 1'b0;
            src_q        <= SRC_SCAN;
        end else begin
            port_en_o <= accept;
            if (accept) begin
                port_we_o    <= req_we;
                port_addr_o  <= req_addr;
                port_wdata_o <= req_wdata;
                src_q        <= req_src;
                pending      <= 1'b1;
            end else if (port_rdy_i) begin
                pending      <= 1'b0;
            end
        end
    end

    // R9: enable is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        port_en_o |=> !port_en_o);

    // R9: no enable while a reply is still outstanding
    a_r9_no_en_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !port_rdy_i) |=> !port_en_o);

    // R2: request fields hold between enables
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_o |-> ($stable(port_addr_o) && $stable(port_wdata_o) && $stable(port_we_o)));

    // R5: scan requests are reads only
    a_r5_scan_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en_o && src_q == SRC_SCAN) |-> !port_we_o);

endmodule

// File: rtl/cfgport_scan.sv
module cfgport_scan
    import cfgport_pkg::*;
#(
    parameter int          AW        = 7,
    parameter int          DW        = 16,
    parameter int          N_CH      = 3,
    parameter logic [AW-1:0] SCAN_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sw,
    input  logic               accept_scan,
    input  logic               done_scan,
    input  logic [DW-1:0]      port_rdata_i,
    output logic               req_valid,
    output logic [AW-1:0]      req_addr,
    output logic               parked,
    output logic [N_CH*DW-1:0] scan_vals_o
);

    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [IW-1:0] LAST_CH = IW'(N_CH - 1);

    scan_state_t st, st_nxt;
    logic [IW-1:0] ch_idx;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SCAN_ISSUE:  if (mode_sw)          st_nxt = SCAN_PARKED;
                         else if (accept_scan) st_nxt = SCAN_WAIT;
            SCAN_WAIT:   if (done_scan)        st_nxt = mode_sw ? SCAN_PARKED : SCAN_ISSUE;
            SCAN_PARKED: if (!mode_sw)         st_nxt = SCAN_ISSUE;
            default:                           st_nxt = SCAN_ISSUE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SCAN_ISSUE;
        else        st <= st_nxt;
    end

    assign req_valid = (st == SCAN_ISSUE) && !mode_sw;
    assign req_addr  = SCAN_BASE + AW'(ch_idx);
    assign parked    = (st == SCAN_PARKED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_idx      <= '0;
            scan_vals_o <= '0;
        end else if (st == SCAN_WAIT && done_scan) begin
            scan_vals_o[ch_idx*DW +: DW] <= port_rdata_i;
            ch_idx <= (ch_idx == LAST_CH) ? '0 : ch_idx + 1'b1;
        end
    end

    // R6: mode set with nothing in flight parks at once
    a_r6_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sw && st == SCAN_ISSUE) |=> (st == SCAN_PARKED));

    // R6: mode set while waiting parks after the reply
    a_r6_park_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sw && st == SCAN_WAIT && done_scan) |=> (st == SCAN_PARKED));

    // R7: clearing the mode leaves the parked state
    a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sw && st == SCAN_PARKED) |=> (st == SCAN_ISSUE));

    // R5: channel index stays in range
    a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        ch_idx <= LAST_CH);

endmodule

// File: rtl/cfgport_sw.sv
module cfgport_sw
    import cfgport_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sw,
    input  logic          parked,
    input  logic          pending,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          done_sw,
    input  logic [DW-1:0] port_rdata_i,
    output logic          req_valid,
    output logic          req_we,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic          ready_o,
    output logic [DW-1:0] rdata_o,
    output logic          overrun_o
);

    sw_state_t st, st_nxt;
    logic any_stb;

    assign any_stb   = rd_stb || wr_stb;
    assign req_valid = any_stb && mode_sw && parked && (st == SW_IDLE) && !pending;
    assign req_we    = wr_stb;
    assign req_addr  = addr_i;
    assign req_wdata = wdata_i;
    assign ready_o   = (st == SW_IDLE);

    always_comb begin
        st_nxt = st;
        unique case (st)
            SW_IDLE: if (req_valid) st_nxt = SW_BUSY;
            SW_BUSY: if (done_sw)   st_nxt = SW_IDLE;
            default:                st_nxt = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SW_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o   <= '0;
            overrun_o <= 1'b0;
        end else begin
            if (done_sw)
                rdata_o <= port_rdata_i;
            if (any_stb && !req_valid)
                overrun_o <= 1'b1;
        end
    end

    // R4: accepted strobe drops ready
    a_r4_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !ready_o);

    // R4: reply raises ready and latches data
    a_r4_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        done_sw |=> (ready_o && rdata_o == $past(port_rdata_i)));

    // R8: overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R6: software only issues while the scan machine is parked
    a_r6_sw_needs_park: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (parked && mode_sw));

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter int            AW        = 7,
    parameter int            DW        = 16,
    parameter int            N_CH      = 3,
    parameter logic [AW-1:0] SCAN_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_mode_i,
    input  logic               sw_rd_stb_i,
    input  logic               sw_wr_stb_i,
    input  logic [AW-1:0]      sw_addr_i,
    input  logic [DW-1:0]      sw_wdata_i,
    output logic               sw_ready_o,
    output logic [DW-1:0]      sw_rdata_o,
    output logic               sw_overrun_o,
    output logic [N_CH*DW-1:0] scan_vals_o,
    output logic               port_en_o,
    output logic               port_we_o,
    output logic [AW-1:0]      port_addr_o,
    output logic [DW-1:0]      port_wdata_o,
    input  logic [DW-1:0]      port_rdata_i,
    input  logic               port_rdy_i
);

    logic          accept, pending, done_scan, done_sw, parked;
    logic          scan_valid, sw_valid, sw_we;
    logic [AW-1:0] scan_addr, sw_addr;
    logic [DW-1:0] sw_wd;

    logic          req_valid, req_we;
    req_src_t      req_src;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;

    always_comb begin
        if (parked) begin
            req_valid = sw_valid;
            req_src   = SRC_SW;
            req_we    = sw_we;
            req_addr  = sw_addr;
            req_wdata = sw_wd;
        end else begin
            req_valid = scan_valid;
            req_src   = SRC_SCAN;
            req_we    = 1'b0;
            req_addr  = scan_addr;
            req_wdata = '0;
        end
    end

    cfgport_scan #(.AW(AW), .DW(DW), .N_CH(N_CH), .SCAN_BASE(SCAN_BASE)) u_scan (
        .clk(clk), .rst_n(rst_n), .mode_sw(sw_mode_i),
        .accept_scan(accept && !parked), .done_scan(done_scan),
        .port_rdata_i(port_rdata_i), .req_valid(scan_valid), .req_addr(scan_addr),
        .parked(parked), .scan_vals_o(scan_vals_o)
    );

    cfgport_sw #(.AW(AW), .DW(DW)) u_sw (
        .clk(clk), .rst_n(rst_n), .mode_sw(sw_mode_i), .parked(parked),
        .pending(pending), .rd_stb(sw_rd_stb_i), .wr_stb(sw_wr_stb_i),
        .addr_i(sw_addr_i), .wdata_i(sw_wdata_i), .done_sw(done_sw),
        .port_rdata_i(port_rdata_i), .req_valid(sw_valid), .req_we(sw_we),
        .req_addr(sw_addr), .req_wdata(sw_wd), .ready_o(sw_ready_o),
        .rdata_o(sw_rdata_o), .overrun_o(sw_overrun_o)
    );

    cfgport_issue #(.AW(AW), .DW(DW)) u_issue (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .port_rdy_i(port_rdy_i), .accept(accept), .pending(pending),
        .done_scan(done_scan), .done_sw(done_sw), .port_en_o(port_en_o),
        .port_we_o(port_we_o), .port_addr_o(port_addr_o), .port_wdata_o(port_wdata_o)
    );

    // R1: an accepted software strobe reaches the port on the next cycle
    a_r1_en_next: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |=> (port_en_o && port_addr_o == $past(sw_addr_i)));

    // R3: write strobe wins when both are raised
    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_wr_stb_i) |=> port_we_o);

endmodule

// File: tb/test_cfgport_bridge.sv
module test_cfgport_bridge;

    localparam int AW = 7;
    localparam int DW = 16;
    localparam int N_CH = 3;
    localparam int NV = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic sw_ready, sw_ovr;
    logic [DW-1:0] sw_rdata;
    logic [N_CH*DW-1:0] scan_vals;
    logic p_en, p_we, p_rdy;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata, p_rdata;

    int checks = 0, fails = 0;
    int en_cnt = 0, consec = 0, cycles = 0;
    int lat = 1;
    logic en_prev = 1'b0;

    always #2.5 clk = ~clk;

    cfgport_bridge #(.AW(AW), .DW(DW), .N_CH(N_CH), .SCAN_BASE('0)) i_cfgport_bridge (
        .clk(clk), .rst_n(rst_n), .sw_mode_i(mode), .sw_rd_stb_i(rd_stb),
        .sw_wr_stb_i(wr_stb), .sw_addr_i(s_addr), .sw_wdata_i(s_wdata),
        .sw_ready_o(sw_ready), .sw_rdata_o(sw_rdata), .sw_overrun_o(sw_ovr),
        .scan_vals_o(scan_vals), .port_en_o(p_en), .port_we_o(p_we),
        .port_addr_o(p_addr), .port_wdata_o(p_wdata), .port_rdata_i(p_rdata),
        .port_rdy_i(p_rdy)
    );

    // macro model: register file with a programmable reply latency
    logic [DW-1:0] mem [2**AW];
    int cnt = 0;
    logic [DW-1:0] hold = '0;
    initial begin
        for (int a = 0; a < 2**AW; a++) mem[a] = DW'(16'h1000 + a * 16'h0101);
        p_rdy = 1'b0;
        p_rdata = '0;
    end
    always @(posedge clk) begin
        p_rdy <= 1'b0;
        if (cnt == 1) begin
            p_rdy <= 1'b1;
            p_rdata <= hold;
            cnt <= 0;
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
        end
        if (p_en) begin
            hold <= mem[p_addr];
            if (p_we) mem[p_addr] <= p_wdata;
            cnt <= lat;
        end
    end

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (p_en) en_cnt <= en_cnt + 1;
            if (p_en && en_prev) consec <= consec + 1;
            en_prev <= p_en;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 200 && !sw_ready; k++) @(negedge clk);
    endtask

    task automatic sw_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit both, input bit chk_rd, input logic [DW-1:0] exp);
        @(negedge clk);
        s_addr = a; s_wdata = d;
        wr_stb = we | both; rd_stb = ~we | both;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        chk(p_en == 1'b1, "R1 en one cycle after strobe", 64'(p_en), 64'd1);
        chk(p_addr == a && p_wdata == (we|both ? d : p_wdata), "R2 fields with enable", 64'(p_addr), 64'(a));
        chk(p_we == (we | both), "R3 write-enable", 64'(p_we), 64'(we | both));
        chk(sw_ready == 1'b0, "R4 ready cleared", 64'(sw_ready), 64'd0);
        @(negedge clk);
        chk(p_en == 1'b0, "R1 en single cycle", 64'(p_en), 64'd0);
        wait_ready();
        chk(sw_ready == 1'b1, "R4 ready set", 64'(sw_ready), 64'd1);
        if (chk_rd) chk(sw_rdata == exp, "R4 read data", 64'(sw_rdata), 64'(exp));
    endtask

    // {we, addr, wdata, expected read}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 7'd5, 16'h1234, 16'h0000},
        {1'b0, 7'd5, 16'h0000, 16'h1234},
        {1'b0, 7'd2, 16'h0000, 16'h1202},
        {1'b1, 7'd9, 16'hBEEF, 16'h0000},
        {1'b0, 7'd9, 16'h0000, 16'hBEEF},
        {1'b1, 7'd2, 16'h0F0F, 16'h0000},
        {1'b0, 7'd2, 16'h0000, 16'h0F0F}
    };

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(p_en == 0 && sw_ready == 1 && sw_ovr == 0 && scan_vals == '0,
            "R10 reset state", 64'({p_en, sw_ready, sw_ovr}), 64'b010);
        rst_n = 1'b1;

        // R5 scan in mode 0
        repeat (60) @(negedge clk);
        for (int c = 0; c < N_CH; c++)
            chk(scan_vals[c*DW +: DW] == DW'(16'h1000 + c * 16'h0101), "R5 scan slot",
                64'(scan_vals[c*DW +: DW]), 64'(16'h1000 + c * 16'h0101));

        // R6/R8 handover with a long reply, strobe during handover
        lat = 12;
        @(negedge clk);
        while (!p_en) @(negedge clk);
        base = en_cnt + 1;
        mode = 1'b1; wr_stb = 1'b1; s_addr = 7'd20; s_wdata = 16'hDEAD;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (30) @(negedge clk);
        chk(en_cnt == base, "R6 no scan issue after mode set", 64'(en_cnt), 64'(base));
        chk(sw_ovr == 1'b1, "R8 overrun on handover strobe", 64'(sw_ovr), 64'd1);
        chk(mem[20] == DW'(16'h1000 + 20 * 16'h0101), "R8 handover strobe no write", 64'(mem[20]), 64'(16'h1000 + 20 * 16'h0101));

        // table of software accesses (R1-R4)
        for (int v = 0; v < NV; v++) begin
            lat = (v % 3) + 1;
            sw_op(VEC[v][39], VEC[v][38:32], VEC[v][31:16], 1'b0, !VEC[v][39], VEC[v][15:0]);
        end

        // R3 both strobes -> write
        sw_op(1'b0, 7'd12, 16'h7777, 1'b1, 1'b0, '0);
        sw_op(1'b0, 7'd12, 16'h0000, 1'b0, 1'b1, 16'h7777);

        // R8 strobe while busy
        lat = 8;
        @(negedge clk);
        base = en_cnt;
        s_addr = 7'd9; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        @(negedge clk); @(negedge clk);
        s_addr = 7'd9; s_wdata = 16'hDEAD; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        wait_ready();
        chk(en_cnt == base + 1, "R8 busy strobe no access", 64'(en_cnt), 64'(base + 1));
        lat = 1;
        sw_op(1'b0, 7'd9, '0, 1'b0, 1'b1, 16'hBEEF);

        // R7 resume scan, channel 2 now 0x0F0F; strobe in mode 0 ignored (R8)
        sw_op(1'b1, 7'd1, 16'h5A5A, 1'b0, 1'b0, '0);
        @(negedge clk);
        mode = 1'b0;
        repeat (4) @(negedge clk);
        wr_stb = 1'b1; s_addr = 7'd30; s_wdata = 16'hAAAA;
        @(negedge clk); wr_stb = 1'b0;
        repeat (60) @(negedge clk);
        chk(scan_vals[1*DW +: DW] == 16'h5A5A, "R7 resumed scan ch1", 64'(scan_vals[1*DW +: DW]), 64'h5A5A);
        chk(scan_vals[2*DW +: DW] == 16'h0F0F, "R7 resumed scan ch2", 64'(scan_vals[2*DW +: DW]), 64'h0F0F);
        chk(mem[30] == DW'(16'h1000 + 30 * 16'h0101), "R8 mode-0 strobe no write", 64'(mem[30]), 64'(16'h1000 + 30 * 16'h0101));
        chk(sw_ovr == 1'b1, "R8 overrun sticky", 64'(sw_ovr), 64'd1);

        // R9 over the whole run
        chk(consec == 0, "R9 no back-to-back enable", 64'(consec), 64'd0);
        finish_run();
    end

endmodule